// File: doc/BRIEF.md
# Mask-Driven Bit-Field Load/Store Unit

This unit performs one of two byte-wide bit-field operations, chosen when `start` is pulsed. Both operations take an 8-bit immediate mask.

- **Field load** reads one byte over the memory port. It keeps only the bits under the mask and shifts them down so that the mask's lowest set bit lands on bit 0. The result goes into the low byte of a register-wide result word. The upper bits of that word come unchanged from the register operand.
- **Field store** takes the low bits of the register operand and moves them up to the mask's lowest set bit. It then merges them into a destination byte in memory with a read-modify-write. Bits outside the mask are left as they were.

The shift distance is never an operand. A priority encoder derives it from the mask.

The memory side is a request/acknowledge port. The unit raises `mem_req`, with `mem_we` low for a read or high for a write. It holds the address and write data until `mem_ack`, and read data is taken in the acknowledge cycle. The surrounding pipeline supplies the address and the operands at `start`, watches `busy`, and picks up `result` on the single-cycle `done` pulse.

Top module: `bitfield_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_req` and `mem_we` are 0 and `result` is 0.
- R2: A field load returns, in `result[7:0]`, the read byte ANDed with the mask and shifted right by the index of the mask's least significant 1 bit, with the bits above the field zero (source 0xA5: mask 0x3C gives 0x09, mask 0xFE gives 0x52).
- R3: A field load copies `reg_val[31:8]` unchanged into `result[31:8]`.
- R4: A field store writes (old AND NOT mask) OR ((reg_val[7:0] shifted left by the lowest set index) AND mask). For example, register 0xA5 into 0xC3 under mask 0x3C gives 0xD7.
- R5: A zero mask gives a load result byte of 0, and a store that writes back the old byte unchanged.
- R6: A load makes exactly one read, with `done` sampled 3 cycles after the start edge when memory acknowledges one cycle after each request. A store makes exactly one read and then one write to the same address, with `done` 5 cycles after the start edge.
- R7: `busy` is high from the cycle after `start` until `done`. `done` lasts one cycle, and `busy` is low while `done` is high.
- R8: `start` is ignored while `busy` is high. No further memory access and no extra `done` follow.
- R9: A field store leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op_store | input | 1 | 0 = field load, 1 = field store |
| mask | input | DW (8) | Immediate field mask |
| reg_val | input | RW (32) | Register operand; low byte is the store source |
| addr | input | AW (8) | Byte address of the operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RW (32) | Load result: upper register bits and extracted field |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW (8) | Memory address |
| mem_wdata | output | DW (8) | Write data |
| mem_rdata | input | DW (8) | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory accepts the request |

## Verification
The hardest case to reach from the ports is a second `start` arriving in the middle of a store, between its read and its write. The bench gets there by raising `start` with different operands (a load to another address) while the store is still busy. It then confirms that the access counts, the target byte and `done` reflect only the first operation. It also confirms that bits outside the mask survive when the destination already holds ones; this needs a destination byte preloaded through the memory model, not the zeroed bytes most vectors use.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bfu_state_e;
endpackage

// File: rtl/bfu_lsb_idx.sv
module bfu_lsb_idx #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins; an all-zero vector yields 0
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bfu_field.sv
module bfu_field #(
  parameter int W = 8
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] src_byte,
  input  logic [W-1:0] ins_val,
  output logic [W-1:0] extracted,
  output logic [W-1:0] merged
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [IW-1:0] sh;
  logic [W-1:0]  placed;

  bfu_lsb_idx #(.W(W)) u_idx (.vec(mask), .idx(sh));

  assign extracted = (src_byte & mask) >> sh;
  assign placed    = ins_val << sh;

  for (genvar g = 0; g < W; g++) begin : g_merge
    assign merged[g] = mask[g] ? placed[g] : src_byte[g];
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_store,
  input  logic [DW-1:0] mask,
  input  logic [RW-1:0] reg_val,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] result,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int UW = RW - DW;

  bfu_state_e    state_q;
  logic          op_q;
  logic [DW-1:0] mask_q;
  logic [RW-1:0] val_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [RW-1:0] result_q;
  logic          req_q, we_q, done_q;

  logic [DW-1:0] fld_ext, fld_mrg;

  bfu_field #(.W(DW)) u_field (
    .mask      (mask_q),
    .src_byte  (mem_rdata),
    .ins_val   (val_q[DW-1:0]),
    .extracted (fld_ext),
    .merged    (fld_mrg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= 1'b0;
      mask_q   <= '0;
      val_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      result_q <= '0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_store;
            mask_q  <= mask;
            val_q   <= reg_val;
            addr_q  <= addr;
            req_q   <= 1'b1;
            we_q    <= 1'b0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (op_q) begin
              wdata_q <= fld_mrg;
              we_q    <= 1'b1;
              state_q <= ST_WRITE;
            end else begin
              result_q <= {val_q[RW-1:DW], fld_ext};
              req_q    <= 1'b0;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [UW-1:0] unused_hi;
  assign unused_hi = '0;

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign result    = result_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mask_q
);
  logic [DW-1:0] last_rd;

  always_ff @(posedge clk) begin
    if (rst) last_rd <= '0;
    else if (mem_req && !mem_we && mem_ack) last_rd <= mem_rdata;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_req_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));

  p_keep_outside_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata & ~mask_q) == (last_rd & ~mask_q)));

  p_wdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && $past(mem_req && mem_we)) |-> $stable(mem_wdata));
endmodule

bind bitfield_unit bfu_checker #(.AW(AW), .DW(DW)) u_bfu_checker (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .mask_q    (mask_q)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_store = 1'b0;
  logic [7:0]  mask = '0;
  logic [31:0] reg_val = '0;
  logic [7:0]  addr = '0;
  logic        busy, done;
  logic [31:0] result;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op_store(op_store), .mask(mask),
    .reg_val(reg_val), .addr(addr), .busy(busy), .done(done), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: acknowledges one cycle after each request
  logic [7:0] mem [16];
  int         rd_cnt = 0;
  int         wr_cnt = 0;
  logic       pre_en = 1'b0;
  logic [3:0] pre_a = '0;
  logic [7:0] pre_d = '0;

  always @(posedge clk) begin
    if (pre_en) mem[pre_a] <= pre_d;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_a = a; pre_d = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_op(input bit st, input logic [7:0] m, input logic [31:0] rv,
                        input logic [7:0] a, output int lat, output bit busy1);
    @(negedge clk);
    start = 1'b1; op_store = st; mask = m; reg_val = rv; addr = a;
    @(negedge clk);
    start = 1'b0;
    busy1 = busy;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // {store, mask, reg low byte, initial mem byte, expected}
  localparam int NV = 29;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'hA5, 8'hA5, 8'h01}, {1'b0, 8'h02, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 8'h07, 8'hA5, 8'hA5, 8'h05}, {1'b0, 8'h10, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 8'h20, 8'hA5, 8'hA5, 8'h01}, {1'b0, 8'hF0, 8'hA5, 8'hA5, 8'h0A},
    {1'b0, 8'h80, 8'hA5, 8'hA5, 8'h01}, {1'b0, 8'h40, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 8'hE0, 8'hA5, 8'hA5, 8'h05}, {1'b0, 8'h3C, 8'hA5, 8'hA5, 8'h09},
    {1'b0, 8'hFE, 8'hA5, 8'hA5, 8'h52}, {1'b0, 8'h00, 8'hA5, 8'hA5, 8'h00},
    {1'b0, 8'h06, 8'hA5, 8'h5A, 8'h01},
    {1'b1, 8'h01, 8'hA5, 8'h00, 8'h01}, {1'b1, 8'h02, 8'hA5, 8'h00, 8'h02},
    {1'b1, 8'h07, 8'hA5, 8'h00, 8'h05}, {1'b1, 8'h10, 8'hA5, 8'h00, 8'h10},
    {1'b1, 8'h20, 8'hA5, 8'h00, 8'h20}, {1'b1, 8'hF0, 8'hA5, 8'h00, 8'h50},
    {1'b1, 8'h80, 8'hA5, 8'h00, 8'h80}, {1'b1, 8'h40, 8'hA5, 8'h00, 8'h40},
    {1'b1, 8'hE0, 8'hA5, 8'h00, 8'hA0}, {1'b1, 8'h3C, 8'hA5, 8'h00, 8'h14},
    {1'b1, 8'hFE, 8'hA5, 8'h00, 8'h4A}, {1'b1, 8'h00, 8'hA5, 8'h00, 8'h00},
    {1'b1, 8'h38, 8'hA5, 8'h00, 8'h28}, {1'b1, 8'h3C, 8'hA5, 8'hC3, 8'hD7},
    {1'b1, 8'h00, 8'hA5, 8'hC3, 8'hC3}, {1'b1, 8'h0F, 8'h3C, 8'hFF, 8'hFC}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    bit b1;
    int r0, w0;
    logic [31:0] prev;
    logic [3:0] a;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !mem_we, "R1 control", {busy, done, mem_req, mem_we}, 0);
    chk(result == 0, "R1 result", result, 0);

    for (int i = 0; i < NV; i++) begin
      a = 4'(i);
      preload(a, VEC[i][15:8]);
      r0 = rd_cnt; w0 = wr_cnt; prev = result;
      run_op(VEC[i][32], VEC[i][31:24], {24'hA5A5A5, VEC[i][23:16]}, {4'h0, a}, lat, b1);
      chk(b1, "R7 busy after start", 32'(b1), 1);
      if (!VEC[i][32]) begin
        chk(result[7:0] == VEC[i][7:0], (VEC[i][31:24] == 0) ? "R5 load zero mask" : "R2 load field",
            result[7:0], VEC[i][7:0]);
        chk(result[31:8] == 24'hA5A5A5, "R3 upper bits", result[31:8], 24'hA5A5A5);
        chk(lat == 3 && rd_cnt - r0 == 1 && wr_cnt == w0, "R6 load access", lat, 3);
      end else begin
        chk(mem[a] == VEC[i][7:0], (VEC[i][31:24] == 0) ? "R5 store zero mask" : "R4 store merge",
            mem[a], VEC[i][7:0]);
        chk(lat == 5 && rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R6 store access", lat, 5);
        chk(result == prev, "R9 result kept", result, prev);
      end
      @(negedge clk);
      chk(!done && !busy, "R7 done pulse", {done, busy}, 0);
    end

    // R3 with a different upper pattern
    preload(4'h2, 8'hF0);
    run_op(1'b0, 8'hF0, 32'h1234_5600, 8'h02, lat, b1);
    chk(result == 32'h1234_560F, "R3 upper pattern", result, 32'h1234_560F);

    // R8 start during a busy store is ignored
    preload(4'h3, 8'h00);
    preload(4'h9, 8'h77);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; op_store = 1'b1; mask = 8'hFF; reg_val = 32'h0000_005A; addr = 8'h03;
    @(negedge clk);
    op_store = 1'b0; mask = 8'h0F; addr = 8'h09;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(mem[3] == 8'h5A, "R8 first op data", mem[3], 8'h5A);
    repeat (8) begin
      @(negedge clk);
      chk(!done && !busy, "R8 no second op", {done, busy}, 0);
    end
    chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R8 access count", rd_cnt - r0, 1);
    chk(mem[9] == 8'h77, "R8 other byte", mem[9], 8'h77);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule